// File: doc/BRIEF.md
# Watchdog Timer with Activity Reload

This block is a watchdog timer controlled through three byte-wide registers on a simple synchronous read/write port. The host writes a binary time-out count. The counter then steps down once for each pulse on an external time-base tick. When the count reaches zero, the block raises a sticky expiry flag. Rising edges on selected peripheral activity lines (joystick, keyboard, mouse) restart the count from the stored time-out value, so the watchdog fires only after a period with no activity.

An expiry can also toggle a power LED output. While the flag stays set, the block drives one of up to fifteen interrupt lines, chosen by a 4-bit map. A time-out can also be forced in two ways. Software can set a self-clearing control bit. A gated external force line can trigger it on its rising edge. All three sources act as one expiry event. The host clears the flag by writing 1 to it.

Register addresses are 0 (time-out value), 1 (configuration) and 2 (control/status). Address 3 reads zero.

Top module: `act_wdt`

## Requirements
- R1: After reset all three registers read 0x00, `led_o` is 0 and every `irq_o` line is 0.
- R2: The time-out register keeps the low TMO_W bits of the written byte and reads them back zero-extended. The configuration register reads back all 8 bits. In the control register, bits 7:4 and bit 2 (outside its one set cycle) read 0, and bit 3 reads back as written.
- R3: Writing a time-out value N (nonzero after truncation) loads the counter with N. Each clock with `tick_i` high decrements the counter. The expiry flag (control bit 0) sets at the clock edge of the N-th tick and not before.
- R4: A stored time-out value of zero disables the watchdog: ticks never cause an expiry. Writing zero during a count cancels that count.
- R5: Configuration bit 0 enables joystick activity (`act_i[0]`), bit 1 enables keyboard activity (`act_i[1]`) and bit 2 enables mouse activity (`act_i[2]`). A rising edge on an enabled line reloads the counter from the time-out register. A line whose enable bit is clear has no effect. A line held high does not reload again.
- R6: After an expiry the counter stays at zero, and further ticks cause no further expiry event until the counter is loaded or reloaded.
- R7: The expiry flag stays set until the host writes a control byte with bit 0 set. A control write with bit 0 clear leaves the flag unchanged.
- R8: When configuration bit 3 is set, each expiry event toggles `led_o` once. When bit 3 is clear, expiry leaves `led_o` unchanged.
- R9: Writing a control byte with bit 1 set toggles `led_o`. Control bit 1 reads the current LED state.
- R10: Writing a control byte with bit 2 set makes bit 2 read 1 for exactly one cycle. At the next clock edge the expiry flag sets, whatever the time-out value, and bit 2 returns to 0.
- R11: While control bit 3 is set, a rising edge on `ext_force_i` sets the expiry flag. While control bit 3 is clear, `ext_force_i` is ignored.
- R12: With configuration bits 7:4 equal to k (1..NUM_IRQ) and the flag set, `irq_o[k-1]` is high and every other line is low. When k is 0 or the flag is clear, all lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable, qualified by `bus_sel_i` |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| tick_i | input | 1 | Time-base pulse, one decrement per high cycle |
| act_i | input | 3 | Activity lines: bit 0 joystick, bit 1 keyboard, bit 2 mouse |
| ext_force_i | input | 1 | External force-timeout line |
| led_o | output | 1 | Power LED drive |
| irq_o | output | NUM_IRQ | Interrupt lines; bit k-1 is line k |

## Verification
The bench builds the block with TMO_W = 4 and NUM_IRQ = 15. With a 4-bit counter it can run every nonzero time-out value, 1 to 15, to expiry and check the exact tick on which the flag sets. It can also check that a written byte wider than the counter is truncated. Keeping all fifteen interrupt lines lets the bench sweep all sixteen map codes and compare each against a one-hot value it computes itself. Each of the three activity lines is tested for reload both with its enable bit set and with it clear.

// File: rtl/act_wdt_pkg.sv
package act_wdt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int NUM_ACT = 3;
  localparam int MAP_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_TMO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd2;

  localparam int CTL_STATUS = 0;
  localparam int CTL_LED    = 1;
  localparam int CTL_FORCE  = 2;
  localparam int CTL_EXTEN  = 3;

  typedef struct packed {
    logic [MAP_W-1:0]   irq_sel;
    logic               led_on_tmo;
    logic [NUM_ACT-1:0] act_en;
  } cfg_t;
endpackage

// File: rtl/act_wdt_edge.sv
module act_wdt_edge #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= in_i[i];
    end
    assign rise_o[i] = in_i[i] & ~prev_q;
  end
endmodule

// File: rtl/act_wdt_cnt.sv
module act_wdt_cnt #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [TMO_W-1:0] load_val_i,
  input  logic             reload_i,
  input  logic [TMO_W-1:0] reload_val_i,
  input  logic             tick_i,
  output logic [TMO_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step = en_i & tick_i & (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)        cnt_d = load_val_i;
    else if (reload_i) cnt_d = reload_val_i;
    else if (step)     cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // expiry only on the 1 -> 0 step
  assign expire_o = step & (cnt_q == ONE) & ~load_i & ~reload_i;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/act_wdt_regs.sv
module act_wdt_regs
  import act_wdt_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [TMO_W-1:0]  tmo_o,
  output cfg_t              cfg_o,
  output logic              ext_en_o,
  output logic              force_o,
  output logic              status_o,
  output logic              led_o,
  output logic              tmo_wr_o,
  output logic              sw_toggle_o,
  output logic              st_clr_o
);
  logic wr, wr_tmo, wr_cfg, wr_ctl;
  logic [TMO_W-1:0] tmo_q;
  cfg_t cfg_q;
  logic ext_en_q, force_q, status_q, led_q;

  assign wr     = sel_i & we_i;
  assign wr_tmo = wr & (addr_i == ADDR_TMO);
  assign wr_cfg = wr & (addr_i == ADDR_CFG);
  assign wr_ctl = wr & (addr_i == ADDR_CTL);

  assign st_clr_o    = wr_ctl & wdata_i[CTL_STATUS];
  assign sw_toggle_o = wr_ctl & wdata_i[CTL_LED];
  assign tmo_wr_o    = wr_tmo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q    <= '0;
      cfg_q    <= '0;
      ext_en_q <= 1'b0;
      force_q  <= 1'b0;
      status_q <= 1'b0;
      led_q    <= 1'b0;
    end else begin
      if (wr_tmo) tmo_q <= wdata_i[TMO_W-1:0];
      if (wr_cfg) cfg_q <= cfg_t'(wdata_i);
      if (wr_ctl) ext_en_q <= wdata_i[CTL_EXTEN];
      force_q <= wr_ctl & wdata_i[CTL_FORCE];
      // set wins over clear
      if (evt_i)         status_q <= 1'b1;
      else if (st_clr_o) status_q <= 1'b0;
      led_q <= led_q ^ sw_toggle_o ^ (evt_i & cfg_q.led_on_tmo);
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_TMO: rdata_o[TMO_W-1:0] = tmo_q;
      ADDR_CFG: rdata_o = cfg_q;
      ADDR_CTL: begin
        rdata_o[CTL_STATUS] = status_q;
        rdata_o[CTL_LED]    = led_q;
        rdata_o[CTL_FORCE]  = force_q;
        rdata_o[CTL_EXTEN]  = ext_en_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign tmo_o    = tmo_q;
  assign cfg_o    = cfg_q;
  assign ext_en_o = ext_en_q;
  assign force_o  = force_q;
  assign status_o = status_q;
  assign led_o    = led_q;
endmodule

// File: rtl/act_wdt_irq.sv
module act_wdt_irq #(
  parameter int NUM_IRQ = 15,
  parameter int MAP_W   = 4
) (
  input  logic               status_i,
  input  logic [MAP_W-1:0]   sel_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  for (genvar k = 1; k <= NUM_IRQ; k++) begin : g_line
    assign irq_o[k-1] = status_i & (sel_i == MAP_W'(k));
  end
endmodule

// File: rtl/act_wdt.sv
module act_wdt
  import act_wdt_pkg::*;
#(
  parameter int TMO_W   = 8,
  parameter int NUM_IRQ = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  input  logic               tick_i,
  input  logic [2:0]         act_i,
  input  logic               ext_force_i,
  output logic               led_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  localparam int EDGE_N = NUM_ACT + 1;

  logic [TMO_W-1:0]  tmo_val, cnt;
  cfg_t              cfg;
  logic              ext_en, force_q, status, tmo_wr, sw_toggle, st_clr;
  logic              en, reload, expire, evt;
  logic [EDGE_N-1:0] rise;

  act_wdt_regs #(.TMO_W(TMO_W)) u_regs (
    .clk_i, .rst_ni,
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .evt_i(evt), .rdata_o(bus_rdata_o),
    .tmo_o(tmo_val), .cfg_o(cfg), .ext_en_o(ext_en), .force_o(force_q),
    .status_o(status), .led_o(led_o), .tmo_wr_o(tmo_wr),
    .sw_toggle_o(sw_toggle), .st_clr_o(st_clr)
  );

  act_wdt_edge #(.N(EDGE_N)) u_edge (
    .clk_i, .rst_ni,
    .in_i({ext_force_i, act_i}),
    .rise_o(rise)
  );

  assign en     = (tmo_val != '0);
  assign reload = en & |(rise[NUM_ACT-1:0] & cfg.act_en);

  act_wdt_cnt #(.TMO_W(TMO_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i(en),
    .load_i(tmo_wr), .load_val_i(bus_wdata_i[TMO_W-1:0]),
    .reload_i(reload), .reload_val_i(tmo_val),
    .tick_i(tick_i),
    .cnt_o(cnt), .expire_o(expire)
  );

  // all sources merge into one event per cycle
  assign evt = expire | force_q | (ext_en & rise[NUM_ACT]);

  act_wdt_irq #(.NUM_IRQ(NUM_IRQ), .MAP_W(MAP_W)) u_irq (
    .status_i(status), .sel_i(cfg.irq_sel), .irq_o(irq_o)
  );
endmodule

// File: rtl/act_wdt_chk.sv
module act_wdt_chk #(
  parameter int TMO_W   = 8,
  parameter int NUM_IRQ = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [TMO_W-1:0]   cnt_i,
  input logic [TMO_W-1:0]   tmo_i,
  input logic               load_i,
  input logic               reload_i,
  input logic               evt_i,
  input logic               status_i,
  input logic               st_clr_i,
  input logic               led_i,
  input logic               sw_toggle_i,
  input logic [NUM_IRQ-1:0] irq_i
);
  AST_IRQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_i)); // R12
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_i) |-> status_i); // R12
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= tmo_i); // R3
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i == '0) |-> (cnt_i == '0)); // R4
  AST_STOP_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && !load_i && !reload_i) |=> (cnt_i == '0)); // R6
  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i && !st_clr_i) |=> status_i); // R7
  AST_EVT_SETS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> status_i); // R3
  AST_LED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !sw_toggle_i) |=> $stable(led_i)); // R8
endmodule

bind act_wdt act_wdt_chk #(.TMO_W(TMO_W), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .tmo_i(tmo_val),
  .load_i(tmo_wr), .reload_i(reload), .evt_i(evt), .status_i(status),
  .st_clr_i(st_clr), .led_i(led_o), .sw_toggle_i(sw_toggle), .irq_i(irq_o)
);

// File: tb/sim_act_wdt.sv
`timescale 1ns/1ps
module sim_act_wdt;
  localparam int TMO_W = 4;
  localparam int NUM_IRQ = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, we = 0, tick = 0, ext = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [2:0] act = '0;
  logic led;
  logic [NUM_IRQ-1:0] irq;
  int n_chk = 0, n_fail = 0;
  logic exp_led = 1'b0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  act_wdt #(.TMO_W(TMO_W), .NUM_IRQ(NUM_IRQ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tick_i(tick), .act_i(act), .ext_force_i(ext), .led_o(led), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    sel = 1; we = 1; addr = a; wdata = d;
    cyc();
    sel = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
    tick = 0;
  endtask

  task automatic pulse_act(input int i);
    act[i] = 1'b1; cyc(); act[i] = 1'b0; cyc();
  endtask

  function automatic logic st();
    return rdata[0];
  endfunction

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // R1
    rd(0, v); chk("R1 tmo reset", v, 0);
    rd(1, v); chk("R1 cfg reset", v, 0);
    rd(2, v); chk("R1 ctl reset", v, 0);
    chk("R1 led reset", led, 0);
    chk("R1 irq reset", irq, 0);
    // R2
    wr(0, 8'hA5); rd(0, v); chk("R2 tmo truncated", v, 8'h05);
    wr(1, 8'h3C); rd(1, v); chk("R2 cfg readback", v, 8'h3C);
    wr(2, 8'hF8); rd(2, v); chk("R2 ctl reserved", v, 8'h08);
    wr(2, 8'h00); rd(2, v); chk("R2 ctl bit3 clear", v, 8'h00);
    wr(0, 8'h00); wr(1, 8'h00);
    // R3, R6, R8 sweep of every nonzero value
    for (int n = 1; n < 16; n++) begin
      logic ledon;
      ledon = n[0];
      wr(1, {4'h0, ledon, 3'b000});
      wr(0, 8'(n)); wr(2, 8'h01);
      ticks(n - 1);
      rd(2, v); chk($sformatf("R3 no early expiry n=%0d", n), st(), 0);
      ticks(1);
      rd(2, v); chk($sformatf("R3 expiry n=%0d", n), st(), 1);
      if (ledon) exp_led = ~exp_led;
      chk($sformatf("R8 led after expiry n=%0d", n), led, exp_led);
      ticks(3);
      chk($sformatf("R6 no repeat event n=%0d", n), led, exp_led);
    end
    wr(1, 8'h00);
    // R4
    wr(0, 8'h00); wr(2, 8'h01); ticks(20);
    rd(2, v); chk("R4 zero never expires", st(), 0);
    wr(0, 8'h05); ticks(2); wr(0, 8'h00); ticks(10);
    rd(2, v); chk("R4 zero cancels count", st(), 0);
    // R5: each source, enabled and disabled
    for (int i = 0; i < 3; i++) begin
      wr(1, 8'(1 << i)); wr(0, 8'h06); wr(2, 8'h01);
      ticks(4); pulse_act(i); ticks(5);
      rd(2, v); chk($sformatf("R5 reload src%0d", i), st(), 0);
      ticks(1);
      rd(2, v); chk($sformatf("R5 reload expiry src%0d", i), st(), 1);
      wr(1, 8'(7 & ~(1 << i))); wr(0, 8'h06); wr(2, 8'h01);
      ticks(4); pulse_act(i); ticks(2);
      rd(2, v); chk($sformatf("R5 disabled src%0d", i), st(), 1);
    end
    wr(1, 8'h04); wr(0, 8'h06); wr(2, 8'h01);
    ticks(3); act[2] = 1; cyc(); ticks(6);
    rd(2, v); chk("R5 held level no second reload", st(), 1);
    act[2] = 0; wr(1, 8'h00); wr(0, 8'h00);
    // R7
    wr(2, 8'h00); rd(2, v); chk("R7 write0 keeps flag", st(), 1);
    wr(2, 8'h01); rd(2, v); chk("R7 write1 clears", st(), 0);
    // R9
    wr(2, 8'h02); exp_led = ~exp_led;
    chk("R9 sw toggle", led, exp_led);
    rd(2, v); chk("R9 led readback", v[1], exp_led);
    wr(2, 8'h02); exp_led = ~exp_led;
    chk("R9 sw toggle back", led, exp_led);
    // R10
    wr(2, 8'h04); rd(2, v);
    chk("R10 force visible", v[2], 1);
    chk("R10 flag not yet", v[0], 0);
    cyc(); rd(2, v);
    chk("R10 force cleared", v[2], 0);
    chk("R10 flag set", v[0], 1);
    // R11
    wr(2, 8'h09); ext = 1; cyc(); ext = 0; cyc();
    rd(2, v); chk("R11 ext force", st(), 1);
    wr(2, 8'h01); ext = 1; cyc(); ext = 0; cyc();
    rd(2, v); chk("R11 ext ignored", st(), 0);
    // R12
    for (int s = 0; s < 16; s++) begin
      logic [NUM_IRQ-1:0] e;
      e = (s == 0) ? '0 : NUM_IRQ'(1) << (s - 1);
      wr(1, 8'(s << 4)); wr(2, 8'h04); cyc();
      chk($sformatf("R12 map %0d", s), irq, e);
      wr(2, 8'h01);
      chk($sformatf("R12 cleared %0d", s), irq, 0);
    end
    chk("R8 led unchanged by map sweep", led, exp_led);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule